// File: doc/BRIEF.md
# Peripheral Sleep Clock Gate Controller

This controller sits beside one peripheral and decides how that peripheral answers a chip-wide sleep request. It drives the enable of the peripheral's functional clock. Two control bits, written through a small register port, choose the behaviour. One bit makes the peripheral ignore sleep. The other bit picks between a graceful stop, where ongoing work finishes first, and a fast stop, where the clock halts at once and a one-cycle abort tells the function to drop what it was doing.

A bus transaction in progress is always allowed to finish before the clock is gated, in either mode. The sleep request is resynchronised through a parameterised flop chain. The control bits in force for one sleep episode are the ones present when that episode began. When the request is withdrawn, the clock enable returns and the peripheral resumes its configured run behaviour.

Top module: `psleep_gate_ctrl`

## Requirements
- R1: After reset, clk_en is 1, abort_pulse is 0 and reg_rd_data reads all zeros with the default reset parameters.
- R2: Register encoding at the default positions: bit 0 is sleep-disable, bit 1 is fast-stop, and bit 2 is a read-only flag that reads 1 while the clock is gated. A write to bit 2 has no effect. A write is visible on reg_rd_data in the cycle after the write edge.
- R3: With sleep-disable 0 and neither busy input high, clk_en falls on the third rising edge after sleep_req rises (two synchroniser stages plus one state update), and the gated flag then reads 1.
- R4: With sleep-disable 1 at the moment the synchronised request arrives, the request is ignored: clk_en stays 1 and the gated flag stays 0.
- R5: With fast-stop 0, clk_en stays 1 while func_busy is high. It falls on the first rising edge that sees func_busy low (and bus_busy low).
- R6: With fast-stop 1, clk_en falls regardless of func_busy. abort_pulse is high for exactly one cycle, coinciding with sleep entry, if and only if func_busy was high at entry.
- R7: In either mode, clk_en stays 1 while bus_busy is high. It falls on the first rising edge that sees bus_busy low.
- R8: clk_en returns to 1 on the third rising edge after sleep_req falls. A request withdrawn while the controller is still waiting for busy work returns it to run without ever gating.
- R9: Control bits written during a sleep episode do not change that episode; they apply from the next sleep entry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Broadcast sleep request (asynchronous) |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | CTRL_W | Control register write data |
| reg_rd_data | output | CTRL_W | Control bits and gated flag |
| bus_busy | input | 1 | Bus transaction in progress |
| func_busy | input | 1 | Peripheral function has work in progress |
| abort_pulse | output | 1 | One-cycle abort request to the function |
| clk_en | output | 1 | Functional clock enable |

## Verification
The bench enters sleep under four input patterns: both busy inputs low, only func_busy high, only bus_busy high, and func_busy high with fast-stop set. Comparing these patterns separates the graceful drain, the bus-completion rule, and the fast stop with its abort. Runs with sleep-disable set show that the request is ignored. Control writes made in the middle of an episode, together with a withdrawal during the drain, show which control bits are sampled when. Separate writes and read-backs confirm the register encoding, including that the flag bit cannot be written.

// File: rtl/psg_pkg.sv
package psg_pkg;
   typedef enum logic [1:0] {
      PSG_RUN   = 2'd0,
      PSG_DRAIN = 2'd1,
      PSG_SLEEP = 2'd2
   } psg_state_e;
endpackage

// File: rtl/psg_sync.sv
module psg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_pass
         logic pass_unused;
         assign pass_unused = clk ^ rst_n;
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= d_in;
               for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign d_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/psg_cfg.sv
module psg_cfg #(
   parameter int   CTRL_W   = 3,
   parameter int   DIS_POS  = 0,
   parameter int   FAST_POS = 1,
   parameter int   STAT_POS = 2,
   parameter logic RST_DIS  = 1'b0,
   parameter logic RST_FAST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              gated,
   output logic              cfg_dis,
   output logic              cfg_fast,
   output logic [CTRL_W-1:0] rd_data
);
   logic dis_q, fast_q;
   logic wr_unused;
   assign wr_unused = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q  <= RST_DIS;
         fast_q <= RST_FAST;
      end else if (wr_en) begin
         dis_q  <= wr_data[DIS_POS];
         fast_q <= wr_data[FAST_POS];
      end
   end

   always_comb begin
      rd_data           = '0;
      rd_data[DIS_POS]  = dis_q;
      rd_data[FAST_POS] = fast_q;
      rd_data[STAT_POS] = gated;
   end

   assign cfg_dis  = dis_q;
   assign cfg_fast = fast_q;
endmodule

// File: rtl/psg_fsm.sv
module psg_fsm
   import psg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_s,
   input  logic cfg_dis,
   input  logic cfg_fast,
   input  logic bus_busy,
   input  logic func_busy,
   output logic clk_en,
   output logic abort,
   output logic gated,
   output logic in_run,
   output logic fast_eff
);
   psg_state_e state_q, state_d;
   logic fast_lat_q, abort_q;
   logic quiet, entry;

   always_comb begin
      fast_eff = (state_q == PSG_RUN) ? cfg_fast : fast_lat_q;
      quiet    = !bus_busy && (fast_eff || !func_busy);
      entry    = (state_q == PSG_RUN) && sleep_s && !cfg_dis;
      state_d  = state_q;
      unique case (state_q)
         PSG_RUN:   if (entry) state_d = quiet ? PSG_SLEEP : PSG_DRAIN;
         PSG_DRAIN: begin
            if (!sleep_s)   state_d = PSG_RUN;
            else if (quiet) state_d = PSG_SLEEP;
         end
         PSG_SLEEP: if (!sleep_s) state_d = PSG_RUN;
         default:   state_d = PSG_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PSG_RUN;
         fast_lat_q <= 1'b0;
         abort_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         abort_q <= entry && cfg_fast && func_busy;
         if (entry) fast_lat_q <= cfg_fast;
      end
   end

   assign clk_en = (state_q != PSG_SLEEP);
   assign gated  = (state_q == PSG_SLEEP);
   assign in_run = (state_q == PSG_RUN);
   assign abort  = abort_q;
endmodule

// File: rtl/psleep_gate_ctrl.sv
module psleep_gate_ctrl #(
   parameter int   CTRL_W      = 3,
   parameter int   DIS_POS     = 0,
   parameter int   FAST_POS    = 1,
   parameter int   STAT_POS    = 2,
   parameter int   SYNC_STAGES = 2,
   parameter logic RST_DIS     = 1'b0,
   parameter logic RST_FAST    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              reg_wr_en,
   input  logic [CTRL_W-1:0] reg_wr_data,
   output logic [CTRL_W-1:0] reg_rd_data,
   input  logic              bus_busy,
   input  logic              func_busy,
   output logic              abort_pulse,
   output logic              clk_en
);
   localparam int MaxPos = CTRL_W - 1;

   generate
      if (CTRL_W < 3) begin : g_bad_w
         $error("CTRL_W must hold three fields");
      end
      if (DIS_POS > MaxPos || FAST_POS > MaxPos || STAT_POS > MaxPos) begin : g_bad_pos
         $error("field position outside register");
      end
      if (DIS_POS == FAST_POS || DIS_POS == STAT_POS || FAST_POS == STAT_POS) begin : g_dup_pos
         $error("field positions overlap");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   logic sleep_s, cfg_dis, cfg_fast, gated, in_run, fast_eff;

   psg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (sleep_req),
      .d_out (sleep_s)
   );

   psg_cfg #(
      .CTRL_W   (CTRL_W),
      .DIS_POS  (DIS_POS),
      .FAST_POS (FAST_POS),
      .STAT_POS (STAT_POS),
      .RST_DIS  (RST_DIS),
      .RST_FAST (RST_FAST)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_data  (reg_wr_data),
      .gated    (gated),
      .cfg_dis  (cfg_dis),
      .cfg_fast (cfg_fast),
      .rd_data  (reg_rd_data)
   );

   psg_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_s   (sleep_s),
      .cfg_dis   (cfg_dis),
      .cfg_fast  (cfg_fast),
      .bus_busy  (bus_busy),
      .func_busy (func_busy),
      .clk_en    (clk_en),
      .abort     (abort_pulse),
      .gated     (gated),
      .in_run    (in_run),
      .fast_eff  (fast_eff)
   );
endmodule

// File: rtl/psg_checker.sv
module psg_checker (
   input logic clk,
   input logic rst_n,
   input logic sleep_s,
   input logic cfg_dis,
   input logic in_run,
   input logic fast_eff,
   input logic bus_busy,
   input logic func_busy,
   input logic abort_pulse,
   input logic clk_en
);
   // R4: a disabled unit in run stays in run
   assert_disable_holds_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_run && cfg_dis |=> in_run);

   // R5: gating while the function was busy only under fast stop
   assert_drain_waits_func_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) && $past(func_busy) |-> $past(fast_eff));

   // R6: abort is a single cycle and only with busy function
   assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> !abort_pulse);
   assert_abort_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> $past(func_busy));

   // R7: never gate over an open bus transaction
   assert_bus_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> $past(!bus_busy));

   // R8: clock returns only after the request is gone
   assert_wake_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> $past(!sleep_s));
endmodule

bind psleep_gate_ctrl psg_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_s     (sleep_s),
   .cfg_dis     (cfg_dis),
   .in_run      (in_run),
   .fast_eff    (fast_eff),
   .bus_busy    (bus_busy),
   .func_busy   (func_busy),
   .abort_pulse (abort_pulse),
   .clk_en      (clk_en)
);

// File: tb/test_psleep_gate_ctrl.sv
`timescale 1ns/1ps
module test_psleep_gate_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [2:0] reg_wr_data = '0;
   logic [2:0] reg_rd_data;
   logic       bus_busy = 1'b0;
   logic       func_busy = 1'b0;
   logic       abort_pulse;
   logic       clk_en;

   always #2 clk = ~clk;

   psleep_gate_ctrl i_psleep_gate_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_data (reg_wr_data),
      .reg_rd_data (reg_rd_data),
      .bus_busy    (bus_busy),
      .func_busy   (func_busy),
      .abort_pulse (abort_pulse),
      .clk_en      (clk_en)
   );

   typedef struct {
      int         cyc;
      logic       ce;
      logic       ab;
      logic [2:0] rd;
      string      tag;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compares scoreboard items due in this cycle
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         item_t it;
         it = q.pop_front();
         total++;
         if (it.cyc < cyc) begin
            bad++;
            $display("FAIL %s: item for cycle %0d missed (now %0d)", it.tag, it.cyc, cyc);
         end else if (clk_en !== it.ce || abort_pulse !== it.ab || reg_rd_data !== it.rd) begin
            bad++;
            $display("FAIL %s cyc=%0d: clk_en=%b exp %b abort=%b exp %b rd=%b exp %b",
                     it.tag, cyc, clk_en, it.ce, abort_pulse, it.ab, reg_rd_data, it.rd);
         end
      end
   end

   task automatic expect_at(input int ofs, input logic ce, input logic ab,
                            input logic [2:0] rd, input string tag);
      item_t it;
      it.cyc = cyc + ofs; it.ce = ce; it.ab = ab; it.rd = rd; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic expect_span(input int from, input int upto, input logic ce,
                              input logic [2:0] rd, input string tag);
      for (int k = from; k <= upto; k++) expect_at(k, ce, 1'b0, rd, tag);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] d);
      reg_wr_en = 1'b1; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wr_data = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      // R1: reset state
      expect_at(1, 1'b1, 1'b0, 3'b000, "R1");
      wait_cyc(2);

      // R2: encoding, status bit not writable
      expect_at(1, 1'b1, 1'b0, 3'b011, "R2");
      wr(3'b111);
      expect_at(1, 1'b1, 1'b0, 3'b000, "R2");
      wr(3'b000);
      wait_cyc(1);

      // R4: disabled unit ignores sleep
      wr(3'b001);
      expect_span(1, 8, 1'b1, 3'b001, "R4");
      sleep_req = 1'b1; wait_cyc(8);
      sleep_req = 1'b0; wait_cyc(4);

      // R3: idle entry, third edge
      wr(3'b000);
      expect_at(2, 1'b1, 1'b0, 3'b000, "R3");
      expect_at(3, 1'b0, 1'b0, 3'b100, "R3");
      sleep_req = 1'b1; wait_cyc(3);
      // R8: release, third edge
      expect_at(2, 1'b0, 1'b0, 3'b100, "R8");
      expect_at(3, 1'b1, 1'b0, 3'b000, "R8");
      sleep_req = 1'b0; wait_cyc(4);

      // R5: graceful stop waits for the function
      func_busy = 1'b1;
      expect_span(1, 6, 1'b1, 3'b000, "R5");
      sleep_req = 1'b1; wait_cyc(6);
      expect_at(1, 1'b0, 1'b0, 3'b100, "R5");
      func_busy = 1'b0; wait_cyc(1);
      expect_at(3, 1'b1, 1'b0, 3'b000, "R8");
      sleep_req = 1'b0; wait_cyc(4);

      // R6: fast stop with busy function aborts for one cycle
      wr(3'b010);
      func_busy = 1'b1;
      expect_at(2, 1'b1, 1'b0, 3'b010, "R6");
      expect_at(3, 1'b0, 1'b1, 3'b110, "R6");
      expect_at(4, 1'b0, 1'b0, 3'b110, "R6");
      sleep_req = 1'b1; wait_cyc(4);
      func_busy = 1'b0;
      expect_at(3, 1'b1, 1'b0, 3'b010, "R8");
      sleep_req = 1'b0; wait_cyc(4);

      // R7: fast stop still lets the bus transaction end (no abort: func idle)
      bus_busy = 1'b1;
      expect_span(1, 6, 1'b1, 3'b010, "R7");
      sleep_req = 1'b1; wait_cyc(6);
      expect_at(1, 1'b0, 1'b0, 3'b110, "R7");
      bus_busy = 1'b0; wait_cyc(1);
      expect_at(3, 1'b1, 1'b0, 3'b010, "R8");
      sleep_req = 1'b0; wait_cyc(4);

      // R9: writes during an episode wait for the next entry
      wr(3'b000);
      func_busy = 1'b1;
      expect_span(1, 4, 1'b1, 3'b000, "R9");
      sleep_req = 1'b1; wait_cyc(4);
      expect_span(1, 4, 1'b1, 3'b010, "R9");
      wr(3'b010); wait_cyc(3);
      expect_at(1, 1'b0, 1'b0, 3'b110, "R9");
      func_busy = 1'b0; wait_cyc(1);
      expect_at(1, 1'b0, 1'b0, 3'b111, "R9");
      expect_at(2, 1'b0, 1'b0, 3'b111, "R9");
      wr(3'b011); wait_cyc(1);
      expect_at(3, 1'b1, 1'b0, 3'b011, "R8");
      sleep_req = 1'b0; wait_cyc(4);
      expect_span(1, 6, 1'b1, 3'b011, "R9");
      sleep_req = 1'b1; wait_cyc(6);
      sleep_req = 1'b0; wait_cyc(4);

      // R8: withdrawal during drain never gates
      wr(3'b000);
      func_busy = 1'b1;
      sleep_req = 1'b1; wait_cyc(4);
      expect_span(1, 6, 1'b1, 3'b000, "R8");
      sleep_req = 1'b0; wait_cyc(6);
      expect_span(1, 3, 1'b1, 3'b000, "R8");
      func_busy = 1'b0; wait_cyc(4);

      while (q.size() > 0) wait_cyc(1);
      finish_run();
   end
endmodule